// File: doc/BRIEF.md
# Preamble Skew Calibrator

This block sits on the host side of a double-rate, two-lane serial read path. Before the first data bit of every read, the memory sends a short training preamble. Each incoming IO lane runs through a chain of delayed copies, called taps. While the preamble-window strobe is high, every tap of every lane is compared in parallel against a programmable expected pattern. When the window closes, the block picks the centre of the longest run of adjacent passing taps for each lane. It then holds that tap for the whole data phase of the read and captures the lane through it.

The logic clock runs at the bit rate, so one clock is one half-cycle of the serial clock. A four-cycle preamble is therefore eight window clocks. The delay line is modelled as a per-lane shift register. Tap k shows the lane value sampled k+1 clock edges earlier.

The block also raises a request for the host to release the IO lines. The request starts in the latency cycles and covers the whole preamble. The block keeps the tap calibrated on the previous read when a window finds no passing tap, and flags that lane.

Top module: `preamble_skew_cal`

## Requirements
- R1: While reset is held and after it is released, with no other activity: every lane's `selTap` equals NUM_TAPS/2, and `calFail`, `ioRelease` and `capValid` are all 0.
- R2: Tap k of lane l, seen at a clock edge, carries the `laneIn[l]` value that was sampled k+1 edges earlier.
- R3: A tap passes a window when, at the i-th edge (i = 0..7) with `preWindow` high, its value equals bit 7-i of that lane's byte `expPattern[8l+7:8l]`. The most significant bit comes first.
- R4: At the first edge that samples `preWindow` low after a window, each lane with a passing tap loads `selTap = s + (n-1)/2`. Here s is the start and n the length of the longest run of adjacent passing taps. If runs tie, the lowest-numbered one wins.
- R5: When a lane has no passing tap, that edge sets its `calFail` to 1 and leaves its `selTap` unchanged. A later window with a passing tap clears `calFail`.
- R6: Lanes are calibrated independently: each lane has its own pattern, pass set, selected tap and fail flag.
- R7: `selTap` changes only at the evaluation edge of a window. It is constant during the data phase that follows.
- R8: After each clock edge m, `capData[l]` equals the `laneIn[l]` value sampled at edge m-t-1, where t is the `selTap[l]` in force before edge m.
- R9: After each edge, `capValid` equals `dataEn` AND `readActive` as sampled at that edge.
- R10: `ioRelease` goes to 1 at an edge that samples `dummyPhase` and `readActive` high. It stays at 1 through the preamble and data phase, and returns to 0 at the first edge that samples `readActive` low.
- R11: Every window re-evaluates from scratch. The pass sets of earlier reads have no influence on a new selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock (one edge per data bit) |
| rstN | input | 1 | Active-low synchronous reset |
| readActive | input | 1 | High for the whole read transaction |
| dummyPhase | input | 1 | High during the latency cycles before the preamble |
| preWindow | input | 1 | High for the eight preamble bit slots |
| dataEn | input | 1 | High while read data is arriving |
| expPattern | input | NUM_LANES*8 | Expected preamble byte per lane, MSB first |
| laneIn | input | NUM_LANES | Raw IO lane samples |
| ioRelease | output | 1 | Request to the host to stop driving the IO lines |
| selTap | output | NUM_LANES*TAP_W | Tap in force per lane |
| calFail | output | NUM_LANES | Last window found no passing tap for the lane |
| capData | output | NUM_LANES | Lane data captured through the selected tap |
| capValid | output | 1 | capData belongs to the data phase |

## Verification
The tap selection and fail flags are due one edge after the window strobe falls. The bench reads them at the falling clock after that edge. Captured data lags `laneIn` by the selected tap plus one edge and is checked against the bench's own record of what it drove, starting from the second data edge, when the new tap is in force. `ioRelease` and `capValid` follow their inputs by one edge and are checked at every falling clock of each read and once after it ends.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam int PRE_BITS = 8;
  localparam int SLOT_W   = $clog2(PRE_BITS);

  typedef struct packed {
    logic              winFirst;
    logic              winOn;
    logic [SLOT_W-1:0] slot;
    logic              evalNow;
  } pscStrobe_t;

endpackage

// File: rtl/psc_ctrl.sv
module psc_ctrl
  import psc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       readActive,
  input  logic       dummyPhase,
  input  logic       preWindow,
  input  logic       dataEn,
  output pscStrobe_t strb,
  output logic       ioRelease,
  output logic       capValid
);

  localparam int CNT_W = SLOT_W + 1;

  logic             winActive;
  logic [CNT_W-1:0] slotCnt;
  logic             firstSlot;

  assign firstSlot    = preWindow && !winActive;
  assign strb.winFirst = firstSlot;
  assign strb.winOn    = preWindow && (firstSlot || (slotCnt < CNT_W'(PRE_BITS)));
  assign strb.slot     = firstSlot ? '0 : slotCnt[SLOT_W-1:0];
  assign strb.evalNow  = winActive && !preWindow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winActive <= 1'b0;
      slotCnt   <= '0;
    end else begin
      winActive <= preWindow;
      if (firstSlot)
        slotCnt <= CNT_W'(1);
      else if (preWindow && (slotCnt < CNT_W'(PRE_BITS)))
        slotCnt <= slotCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioRelease <= 1'b0;
      capValid  <= 1'b0;
    end else begin
      if (!readActive)
        ioRelease <= 1'b0;
      else if (dummyPhase)
        ioRelease <= 1'b1;
      capValid <= dataEn && readActive;
    end
  end

  // R4
  eval_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.evalNow |=> !strb.evalNow);

  // R10
  release_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioRelease) |-> $past(dummyPhase && readActive));

  // R10
  release_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!readActive) |-> !ioRelease);

endmodule

// File: rtl/psc_datapath.sv
module psc_datapath
  import psc_pkg::*;
#(
  parameter int NUM_TAPS  = 16,
  parameter int NUM_LANES = 2,
  localparam int TAP_W    = $clog2(NUM_TAPS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pscStrobe_t                    strb,
  input  logic [NUM_LANES-1:0]          laneIn,
  input  logic [NUM_LANES*PRE_BITS-1:0] expPattern,
  output logic [NUM_LANES*TAP_W-1:0]    selTap,
  output logic [NUM_LANES-1:0]          calFail,
  output logic [NUM_LANES-1:0]          capData
);

  localparam logic [TAP_W-1:0] RESET_TAP = TAP_W'(NUM_TAPS / 2);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [NUM_TAPS-1:0] dly;
    logic [NUM_TAPS-1:0] passAcc;
    logic [NUM_TAPS-1:0] tapMatch;
    logic [PRE_BITS-1:0] lanePat;
    logic                expBit;
    logic [TAP_W-1:0]    laneTap;
    logic [TAP_W-1:0]    centreTap;
    logic                anyPass;

    assign lanePat  = expPattern[l*PRE_BITS +: PRE_BITS];
    assign expBit   = lanePat[SLOT_W'(PRE_BITS - 1) - strb.slot];
    assign tapMatch = ~(dly ^ {NUM_TAPS{expBit}});

    // delay line: dly[k] holds the sample from k+1 edges ago
    always_ff @(posedge clk) begin
      if (!rstN) dly <= '0;
      else       dly <= {dly[NUM_TAPS-2:0], laneIn[l]};
    end

    // parallel compare of all taps across the window
    always_ff @(posedge clk) begin
      if (!rstN)              passAcc <= '0;
      else if (strb.winFirst) passAcc <= tapMatch;
      else if (strb.winOn)    passAcc <= passAcc & tapMatch;
    end

    // longest run of passing taps, lowest run wins ties
    always_comb begin
      int runStart;
      int runLen;
      int bestStart;
      int bestLen;
      runStart  = 0;
      runLen    = 0;
      bestStart = 0;
      bestLen   = 0;
      for (int k = 0; k < NUM_TAPS; k++) begin
        if (passAcc[k]) begin
          if (runLen == 0) runStart = k;
          runLen = runLen + 1;
          if (runLen > bestLen) begin
            bestLen   = runLen;
            bestStart = runStart;
          end
        end else begin
          runLen = 0;
        end
      end
      anyPass   = (bestLen > 0);
      centreTap = anyPass ? TAP_W'(bestStart + (bestLen - 1) / 2) : '0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneTap    <= RESET_TAP;
        calFail[l] <= 1'b0;
      end else if (strb.evalNow) begin
        if (anyPass) begin
          laneTap    <= centreTap;
          calFail[l] <= 1'b0;
        end else begin
          calFail[l] <= 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) capData[l] <= 1'b0;
      else       capData[l] <= dly[laneTap];
    end

    assign selTap[l*TAP_W +: TAP_W] = laneTap;

    // R5
    fail_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(calFail[l]) |-> $stable(laneTap));

    // R5
    tap_move_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
      $changed(laneTap) |-> !calFail[l]);
  end

endmodule

// File: rtl/preamble_skew_cal.sv
module preamble_skew_cal
  import psc_pkg::*;
#(
  parameter int NUM_TAPS  = 16,
  parameter int NUM_LANES = 2,
  localparam int TAP_W    = $clog2(NUM_TAPS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          readActive,
  input  logic                          dummyPhase,
  input  logic                          preWindow,
  input  logic                          dataEn,
  input  logic [NUM_LANES*PRE_BITS-1:0] expPattern,
  input  logic [NUM_LANES-1:0]          laneIn,
  output logic                          ioRelease,
  output logic [NUM_LANES*TAP_W-1:0]    selTap,
  output logic [NUM_LANES-1:0]          calFail,
  output logic [NUM_LANES-1:0]          capData,
  output logic                          capValid
);

  pscStrobe_t strb;

  psc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .readActive (readActive),
    .dummyPhase (dummyPhase),
    .preWindow  (preWindow),
    .dataEn     (dataEn),
    .strb       (strb),
    .ioRelease  (ioRelease),
    .capValid   (capValid)
  );

  psc_datapath #(
    .NUM_TAPS  (NUM_TAPS),
    .NUM_LANES (NUM_LANES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .laneIn     (laneIn),
    .expPattern (expPattern),
    .selTap     (selTap),
    .calFail    (calFail),
    .capData    (capData)
  );

  // R7
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataEn && $past(!preWindow) && $past(!preWindow, 2)) |-> $stable(selTap));

endmodule

// File: tb/preamble_skew_cal_test.sv
module preamble_skew_cal_test;

  localparam int TAPS  = 16;
  localparam int TW    = 4;
  localparam int LANES = 2;
  localparam int LEN   = 48;
  localparam int WIN0  = 20;
  localparam int DAT0  = 28;

  logic clk = 1'b0;
  logic rstN;
  logic readActive, dummyPhase, preWindow, dataEn;
  logic [LANES*8-1:0] expPattern;
  logic [LANES-1:0]   laneIn;
  logic               ioRelease;
  logic [LANES*TW-1:0] selTap;
  logic [LANES-1:0]   calFail;
  logic [LANES-1:0]   capData;
  logic               capValid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [LEN-1:0] drv [LANES];
  int expSel  [LANES];
  bit expFail [LANES];

  always #4 clk = ~clk;

  preamble_skew_cal uut (
    .clk(clk), .rstN(rstN), .readActive(readActive), .dummyPhase(dummyPhase),
    .preWindow(preWindow), .dataEn(dataEn), .expPattern(expPattern),
    .laneIn(laneIn), .ioRelease(ioRelease), .selTap(selTap),
    .calFail(calFail), .capData(capData), .capValid(capValid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[0];
  endfunction

  // R3: tap k passes when its value at window edge i equals pattern bit 7-i
  function automatic logic [TAPS-1:0] passOf(input logic [LEN-1:0] d, input logic [7:0] p);
    logic [TAPS-1:0] v;
    for (int k = 0; k < TAPS; k++) begin
      v[k] = 1'b1;
      for (int i = 0; i < 8; i++)
        if (d[WIN0 + i - k - 1] != p[7 - i]) v[k] = 1'b0;
    end
    return v;
  endfunction

  // R4: centre of the first longest run, -1 when nothing passes
  function automatic int centreOf(input logic [TAPS-1:0] v);
    int bs = 0, bl = 0;
    for (int s = 0; s < TAPS; s++) begin
      int n = 0;
      while (s + n < TAPS && v[s + n]) n++;
      if (n > bl) begin bl = n; bs = s; end
    end
    return (bl == 0) ? -1 : bs + (bl - 1) / 2;
  endfunction

  task automatic checkEdge(input int p);
    chk(ioRelease == 1'b1, "R10", int'(ioRelease), 1);
    chk(capValid == (p >= DAT0), "R9", int'(capValid), int'(p >= DAT0));
    if (p == DAT0 || p == LEN - 1) begin
      for (int l = 0; l < LANES; l++) begin
        // R4 R6 R7 R11
        chk(int'(selTap[l*TW +: TW]) == expSel[l], "R4", int'(selTap[l*TW +: TW]), expSel[l]);
        // R5
        chk(calFail[l] == expFail[l], "R5", int'(calFail[l]), int'(expFail[l]));
      end
    end
    if (p > DAT0) begin
      for (int l = 0; l < LANES; l++) begin
        // R2 R8
        logic e;
        e = drv[l][p - expSel[l] - 1];
        chk(capData[l] == e, "R8", int'(capData[l]), int'(e));
      end
    end
  endtask

  // mode 0: pattern placed for tap t amid random bits; mode 1: lane held at 0
  task automatic doRead(input int t0, input int t1, input logic [7:0] p0,
                        input logic [7:0] p1, input int m0, input int m1);
    int tg [LANES];
    int md [LANES];
    logic [7:0] pt [LANES];
    tg[0] = t0; tg[1] = t1; md[0] = m0; md[1] = m1; pt[0] = p0; pt[1] = p1;
    for (int l = 0; l < LANES; l++) begin
      int c;
      for (int e = 0; e < LEN; e++) drv[l][e] = (md[l] == 1) ? 1'b0 : rnd();
      if (md[l] == 0)
        for (int i = 0; i < 8; i++) drv[l][WIN0 + i - tg[l] - 1] = pt[l][7 - i];
      c = centreOf(passOf(drv[l], pt[l]));
      if (c < 0) expFail[l] = 1'b1;
      else begin expFail[l] = 1'b0; expSel[l] = c; end
    end
    for (int e = 0; e <= LEN; e++) begin
      @(negedge clk);
      if (e > 0) checkEdge(e - 1);
      if (e < LEN) begin
        readActive = 1'b1;
        dummyPhase = (e < WIN0);
        preWindow  = (e >= WIN0 && e < DAT0);
        dataEn     = (e >= DAT0);
        expPattern = {p1, p0};
        laneIn     = {drv[1][e], drv[0][e]};
      end else begin
        readActive = 1'b0; dummyPhase = 1'b0; preWindow = 1'b0; dataEn = 1'b0;
        laneIn = '0;
      end
    end
    @(negedge clk);
    chk(ioRelease == 1'b0, "R10", int'(ioRelease), 0);
    chk(capValid == 1'b0, "R9", int'(capValid), 0);
  endtask

  initial begin
    rstN = 1'b0; readActive = 1'b0; dummyPhase = 1'b0; preWindow = 1'b0;
    dataEn = 1'b0; expPattern = '0; laneIn = '0;
    for (int l = 0; l < LANES; l++) begin expSel[l] = TAPS / 2; expFail[l] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      // R1
      chk(int'(selTap[l*TW +: TW]) == TAPS / 2, "R1", int'(selTap[l*TW +: TW]), TAPS / 2);
      chk(calFail[l] == 1'b0, "R1", int'(calFail[l]), 0);
    end
    chk(ioRelease == 1'b0, "R1", int'(ioRelease), 0);
    chk(capValid == 1'b0, "R1", int'(capValid), 0);

    doRead(5, 9, 8'hA5, 8'h3C, 0, 0);
    doRead(0, 15, 8'h96, 8'h5A, 0, 0);
    // R6 R11: sweep all taps, lanes in opposite directions
    for (int t = 0; t < TAPS; t++) begin
      logic [7:0] pa, pb;
      for (int b = 0; b < 8; b++) begin pa[b] = rnd(); pb[b] = rnd(); end
      pa[7] = 1'b1; pa[0] = 1'b0;
      doRead(t, TAPS - 1 - t, pa, pb, 0, 0);
    end
    // R5: lane 0 sees no passing tap, lane 1 keeps calibrating
    doRead(0, 3, 8'hA5, 8'hC3, 1, 0);
    doRead(0, 11, 8'h0F, 8'h69, 1, 0);
    // R4: every tap passes on lane 1, centre of the full run
    doRead(6, 0, 8'hB4, 8'h00, 0, 1);
    // R5 R11: lane 0 recovers
    doRead(12, 2, 8'hD2, 8'h2D, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule